// File: doc/BRIEF.md
# Audio Sample Clock Source Manager

This block decides the sample rate and the master-clock source of a multichannel audio converter card. Two configuration switches give the preferred rate family (48 kHz or 44.1 kHz) and the sampling mode (nominal or double). An external AES sync receiver reports whether a sync signal is present and its measured rate. A lock flag from the oscillator PLL tells the block when the enabled local oscillator has settled. From these inputs the block enables exactly one of the two family oscillators and steers the master clock. It uses the receiver's recovered clock while the oscillator is still acquiring, and the low-jitter oscillator once it has locked. It also drives the effective rate family and mode, plus colour codes for four front-panel status lights.

When valid external sync is present, its rate family overrides the family switch. The local mode switch alone sets nominal or double rate, whatever rate the sync runs at. A change of mode never swaps the oscillator, because the converter runs from the same master-clock frequency in both modes. A sync rate that belongs to neither family leaves the enabled oscillator as it is. Oscillator lock is watched by a timeout that the system programs. If the timeout runs out, a fault flag is raised and the status light turns red.

Top module: `smpclk_mgr`

## Requirements
- R1: While reset is held, `mclk_recov`, `mclk_valid` and `fault` are 0. At the first clock edge after reset is released, the oscillator of the switch family (`cfg_fam44`: 0 = 48 kHz, 1 = 44.1 kHz) is enabled. `mclk_valid` stays 0 until `osc_lock` is sampled high.
- R2: Exactly one of `osc48_en` and `osc44_en` is high in every cycle out of reset. `eff_fam44` equals `osc44_en`.
- R3: `sync_rate` is in units of 100 Hz. Sync is valid when `sync_det` is 1 and 290 <= `sync_rate` <= 1000. A valid rate within +/-TOL (default 4) of 480 or 960 belongs to the 48 kHz family. A valid rate within TOL of 441 or 882 belongs to the 44.1 kHz family. A valid sync of known family sets the enabled family one edge later, overriding the switch.
- R4: `eff_double` and `led_mode` follow `cfg_double`, independent of the sync rate. Toggling `cfg_double` alone leaves the oscillator enables unchanged.
- R5: On the edge where valid sync is first seen, `mclk_recov` becomes 1 and `mclk_valid` is 1. The block leaves the recovered clock (`mclk_recov` 0) only at an edge, at least one after entry, where `osc_lock` is sampled high.
- R6: A valid sync whose rate is in neither family leaves the enabled oscillator unchanged. The block still takes the recovered clock until lock.
- R7: When sync is lost, the switch family is restored. If no swap is needed, the master clock stays on the locked oscillator (`mclk_valid` 1). If a swap is needed, `mclk_valid` drops to 0 at the next edge and returns only after `osc_lock` is sampled high.
- R8: While the block waits for lock, each edge with `osc_lock` low increments a counter. `fault` rises at the edge where the counter reaches `lock_tmo` (which must be at least 1). When waiting with sync, the recovered clock is kept. `fault` clears at the edge where a lock is accepted.
- R9: `led_status` is red (1) while `fault` is 1, else green (2).
- R10: `led_sync` is red (1) without valid sync. It is green (2) when the sync family equals the switch family, and amber (3) otherwise, including sync outside both families.
- R11: `led_rate` is green (2) for the 48 kHz family and amber (3) for the 44.1 kHz family. It is red (1) while valid sync of neither family is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fam44 | input | 1 | Family switch: 0 = 48 kHz, 1 = 44.1 kHz |
| cfg_double | input | 1 | Mode switch: 0 = nominal, 1 = double rate |
| sync_det | input | 1 | External sync receiver detects a signal |
| sync_rate | input | RATE_W | Measured sync rate, 100 Hz units |
| osc_lock | input | 1 | Enabled oscillator PLL reports lock |
| lock_tmo | input | TMO_W | Lock timeout in clock cycles (>= 1) |
| mclk_recov | output | 1 | 1 = master clock from recovered clock, 0 = local oscillator |
| mclk_valid | output | 1 | Selected master clock is usable |
| osc48_en | output | 1 | Enable for the 48 kHz family oscillator |
| osc44_en | output | 1 | Enable for the 44.1 kHz family oscillator |
| eff_fam44 | output | 1 | Effective rate family |
| eff_double | output | 1 | Effective mode |
| fault | output | 1 | Lock timeout fault |
| led_status | output | 2 | Status light colour code |
| led_sync | output | 2 | External sync light colour code |
| led_rate | output | 2 | Output rate light colour code |
| led_mode | output | 1 | Double-rate light |

## Verification
The oscillator enables, effective family, clock-source flags and fault come from registers, so they respond at the first rising edge after a stimulus. The sync, rate, mode and status lights decode current inputs and registered state without further delay. The bench changes inputs on a falling edge and checks one falling edge later, after exactly one rising edge. Each lock or timeout step is then advanced one edge at a time, so expected values are counted in whole edges. It sweeps every measured rate from 250 to 1020 under both family switch settings, running each through acquisition, handover and loss of sync.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_RECOV  = 2'd1,
    ST_LOCAL  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    LED_OFF   = 2'd0,
    LED_RED   = 2'd1,
    LED_GREEN = 2'd2,
    LED_AMBER = 2'd3
  } led_t;

  typedef struct packed {
    logic valid;   // sync present and inside accepted range
    logic known;   // rate belongs to one of the two families
    logic fam44;   // family of the rate when known
  } sync_class_t;
endpackage

// File: rtl/smpclk_rate_class.sv
module smpclk_rate_class
  import smpclk_pkg::*;
#(
  parameter int RATE_W   = 10,
  parameter int NOM48    = 480,
  parameter int NOM44    = 441,
  parameter int TOL      = 4,
  parameter int MIN_RATE = 290,
  parameter int MAX_RATE = 1000
) (
  input  logic              sync_det,
  input  logic [RATE_W-1:0] sync_rate,
  output sync_class_t       cls
);
  localparam int NREF = 4;   // nominal and double of each family
  localparam logic [RATE_W:0] LO_LIM = (RATE_W+1)'(MIN_RATE);
  localparam logic [RATE_W:0] HI_LIM = (RATE_W+1)'(MAX_RATE);

  logic [RATE_W:0] rate_x;
  logic [NREF-1:0] hit;
  logic            in_range;

  assign rate_x   = {1'b0, sync_rate};
  assign in_range = (rate_x >= LO_LIM) && (rate_x <= HI_LIM);

  // even index: 48 kHz family, odd index: 44.1 kHz family; upper pair doubled
  for (genvar i = 0; i < NREF; i++) begin : g_ref
    localparam int REF = (((i % 2) == 1) ? NOM44 : NOM48) * ((i / 2) + 1);
    localparam logic [RATE_W:0] WIN_LO = (RATE_W+1)'(REF - TOL);
    localparam logic [RATE_W:0] WIN_HI = (RATE_W+1)'(REF + TOL);
    assign hit[i] = (rate_x >= WIN_LO) && (rate_x <= WIN_HI);
  end

  always_comb begin
    cls.valid = sync_det && in_range;
    cls.known = cls.valid && (|hit);
    cls.fam44 = hit[1] | hit[3];
  end
endmodule

// File: rtl/smpclk_seq.sv
module smpclk_seq
  import smpclk_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fam44,
  input  sync_class_t      cls,
  input  logic             osc_lock,
  input  logic [TMO_W-1:0] lock_tmo,
  output logic             osc_fam44,
  output logic             mclk_recov,
  output logic             mclk_valid,
  output logic             fault
);
  localparam logic [TMO_W-1:0] CNT_ONE = TMO_W'(1);

  seq_state_t       state_q;
  logic             fam_q;
  logic             synced_q;
  logic             fault_q;
  logic [TMO_W-1:0] cnt_q;

  logic tgt_fam;
  logic need_swap;
  logic acquire;
  logic waiting;

  always_comb begin
    tgt_fam = cfg_fam44;
    if (cls.valid) tgt_fam = cls.known ? cls.fam44 : fam_q;
  end

  assign need_swap = (tgt_fam != fam_q);
  assign acquire   = cls.valid && !synced_q;
  assign waiting   = (state_q != ST_LOCAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SETTLE;
      fam_q    <= 1'b0;
      synced_q <= 1'b0;
      fault_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      synced_q <= cls.valid;
      if (acquire || need_swap) begin
        fam_q   <= tgt_fam;
        cnt_q   <= '0;
        state_q <= cls.valid ? ST_RECOV : ST_SETTLE;
      end else if (!cls.valid && synced_q && state_q == ST_RECOV) begin
        state_q <= ST_SETTLE;
        cnt_q   <= '0;
      end else if (waiting && osc_lock) begin
        state_q <= ST_LOCAL;
        fault_q <= 1'b0;
        cnt_q   <= '0;
      end else if (waiting && cnt_q < lock_tmo) begin
        cnt_q <= cnt_q + CNT_ONE;
        if (cnt_q + CNT_ONE == lock_tmo) fault_q <= 1'b1;
      end
    end
  end

  assign osc_fam44  = fam_q;
  assign mclk_recov = (state_q == ST_RECOV);
  assign mclk_valid = (state_q != ST_SETTLE);
  assign fault      = fault_q;
endmodule

// File: rtl/smpclk_led.sv
module smpclk_led
  import smpclk_pkg::*;
(
  input  sync_class_t cls,
  input  logic        cfg_fam44,
  input  logic        cfg_double,
  input  logic        osc_fam44,
  input  logic        fault,
  output led_t        led_status,
  output led_t        led_sync,
  output led_t        led_rate,
  output logic        led_mode
);
  always_comb begin
    led_status = fault ? LED_RED : LED_GREEN;

    if (!cls.valid)                                 led_sync = LED_RED;
    else if (cls.known && cls.fam44 == cfg_fam44)   led_sync = LED_GREEN;
    else                                            led_sync = LED_AMBER;

    if (cls.valid && !cls.known) led_rate = LED_RED;
    else if (osc_fam44)          led_rate = LED_AMBER;
    else                         led_rate = LED_GREEN;

    led_mode = cfg_double;
  end
endmodule

// File: rtl/smpclk_mgr.sv
module smpclk_mgr
  import smpclk_pkg::*;
#(
  parameter int RATE_W   = 10,
  parameter int NOM48    = 480,
  parameter int NOM44    = 441,
  parameter int TOL      = 4,
  parameter int MIN_RATE = 290,
  parameter int MAX_RATE = 1000,
  parameter int TMO_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fam44,
  input  logic              cfg_double,
  input  logic              sync_det,
  input  logic [RATE_W-1:0] sync_rate,
  input  logic              osc_lock,
  input  logic [TMO_W-1:0]  lock_tmo,
  output logic              mclk_recov,
  output logic              mclk_valid,
  output logic              osc48_en,
  output logic              osc44_en,
  output logic              eff_fam44,
  output logic              eff_double,
  output logic              fault,
  output logic [1:0]        led_status,
  output logic [1:0]        led_sync,
  output logic [1:0]        led_rate,
  output logic              led_mode
);
  sync_class_t cls;
  logic        osc_fam44;
  led_t        st_led, sy_led, rt_led;

  smpclk_rate_class #(
    .RATE_W(RATE_W), .NOM48(NOM48), .NOM44(NOM44), .TOL(TOL),
    .MIN_RATE(MIN_RATE), .MAX_RATE(MAX_RATE)
  ) u_class (
    .sync_det (sync_det),
    .sync_rate(sync_rate),
    .cls      (cls)
  );

  smpclk_seq #(.TMO_W(TMO_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fam44 (cfg_fam44),
    .cls       (cls),
    .osc_lock  (osc_lock),
    .lock_tmo  (lock_tmo),
    .osc_fam44 (osc_fam44),
    .mclk_recov(mclk_recov),
    .mclk_valid(mclk_valid),
    .fault     (fault)
  );

  smpclk_led u_led (
    .cls       (cls),
    .cfg_fam44 (cfg_fam44),
    .cfg_double(cfg_double),
    .osc_fam44 (osc_fam44),
    .fault     (fault),
    .led_status(st_led),
    .led_sync  (sy_led),
    .led_rate  (rt_led),
    .led_mode  (led_mode)
  );

  assign osc48_en   = !osc_fam44;
  assign osc44_en   = osc_fam44;
  assign eff_fam44  = osc_fam44;
  assign eff_double = cfg_double;
  assign led_status = st_led;
  assign led_sync   = sy_led;
  assign led_rate   = rt_led;
endmodule

// File: rtl/smpclk_mgr_chk.sv
module smpclk_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_det,
  input logic       osc_lock,
  input logic       mclk_recov,
  input logic       mclk_valid,
  input logic       osc48_en,
  input logic       osc44_en,
  input logic       fault,
  input logic [1:0] led_sync
);
  assert_one_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({osc48_en, osc44_en}) == 1);

  assert_acquire_recov_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk_recov) |-> $past(sync_det));

  assert_handover_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mclk_recov) && mclk_valid) |-> $past(osc_lock));

  assert_settle_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mclk_valid) && !mclk_recov) |-> $past(osc_lock));

  assert_fault_nolock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !$past(osc_lock));

  assert_sync_led_red_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_det |-> led_sync == 2'd1);
endmodule

bind smpclk_mgr smpclk_mgr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_det  (sync_det),
  .osc_lock  (osc_lock),
  .mclk_recov(mclk_recov),
  .mclk_valid(mclk_valid),
  .osc48_en  (osc48_en),
  .osc44_en  (osc44_en),
  .fault     (fault),
  .led_sync  (led_sync)
);

// File: tb/sim_smpclk_mgr.sv
module sim_smpclk_mgr;
  localparam int CLK_NS  = 10;
  localparam int RATE_W  = 10;
  localparam int TMO_W   = 16;
  localparam int TOL     = 4;
  localparam int WDOG    = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_fam44 = 1'b1;
  logic              cfg_double = 1'b0;
  logic              sync_det = 1'b0;
  logic [RATE_W-1:0] sync_rate = '0;
  logic              osc_lock = 1'b0;
  logic [TMO_W-1:0]  lock_tmo = 16'd50;
  logic mclk_recov, mclk_valid, osc48_en, osc44_en, eff_fam44, eff_double, fault, led_mode;
  logic [1:0] led_status, led_sync, led_rate;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  smpclk_mgr #(.RATE_W(RATE_W), .TOL(TOL), .TMO_W(TMO_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fam44(cfg_fam44), .cfg_double(cfg_double),
    .sync_det(sync_det), .sync_rate(sync_rate), .osc_lock(osc_lock),
    .lock_tmo(lock_tmo), .mclk_recov(mclk_recov), .mclk_valid(mclk_valid),
    .osc48_en(osc48_en), .osc44_en(osc44_en), .eff_fam44(eff_fam44),
    .eff_double(eff_double), .fault(fault), .led_status(led_status),
    .led_sync(led_sync), .led_rate(led_rate), .led_mode(led_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int near(input int r, input int c);
    return (r >= c - TOL && r <= c + TOL) ? 1 : 0;
  endfunction

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state and power-up family
    repeat (3) @(negedge clk);
    chk("R1 recov in reset", mclk_recov, 0);
    chk("R1 valid in reset", mclk_valid, 0);
    chk("R1 fault in reset", fault, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 switch family enabled", osc44_en, 1);
    chk("R1 no clock before lock", mclk_valid, 0);
    tick();
    chk("R1 still waiting", mclk_valid, 0);
    osc_lock = 1'b1;
    tick();
    chk("R1 locked", mclk_valid, 1);
    chk("R9 status green", led_status, 2);
    chk("R11 rate led 44.1", led_rate, 3);

    // R4: mode only, then double with nominal sync
    cfg_fam44 = 1'b0;
    tick(); tick(); tick();
    cfg_double = 1'b1;
    tick();
    chk("R4 osc48 kept", osc48_en, 1);
    chk("R4 eff_double", eff_double, 1);
    chk("R4 led_mode", led_mode, 1);
    chk("R4 valid kept", mclk_valid, 1);
    sync_rate = 10'd480; sync_det = 1'b1; osc_lock = 1'b0;
    tick();
    chk("R4 fam48 with 48k sync", eff_fam44, 0);
    chk("R4 double kept", eff_double, 1);
    chk("R10 sync led green", led_sync, 2);
    osc_lock = 1'b1; tick();
    sync_det = 1'b0; tick();
    cfg_double = 1'b0; tick();
    chk("R4 nominal", {eff_double, led_mode}, 0);
    chk("R2 one osc", osc48_en + osc44_en, 1);

    // R6: tracking 44.1 sync, then an off-family rate
    sync_rate = 10'd441; sync_det = 1'b1; osc_lock = 1'b0;
    tick();
    chk("R3 sync override", eff_fam44, 1);
    osc_lock = 1'b1; tick();
    chk("R5 handed over", {mclk_recov, mclk_valid}, 1);
    sync_rate = 10'd600;
    tick();
    chk("R6 osc unchanged", eff_fam44, 1);
    chk("R6 local kept", {mclk_recov, mclk_valid}, 1);
    chk("R11 rate led red", led_rate, 1);
    sync_det = 1'b0;
    tick();
    chk("R7 swap back valid low", {mclk_valid, eff_fam44}, 0);
    tick();
    chk("R7 relocked", mclk_valid, 1);

    // R8: timeout while on recovered clock
    lock_tmo = 16'd5;
    sync_rate = 10'd882; sync_det = 1'b1; osc_lock = 1'b0;
    tick();
    chk("R8 entered recov", mclk_recov, 1);
    repeat (4) tick();
    chk("R8 no fault early", fault, 0);
    tick();
    chk("R8 fault at limit", fault, 1);
    chk("R8 recov kept", mclk_recov, 1);
    chk("R9 status red", led_status, 1);
    repeat (3) tick();
    chk("R8 fault held", fault, 1);
    osc_lock = 1'b1; tick();
    chk("R8 fault cleared", fault, 0);
    chk("R8 to local", {mclk_recov, mclk_valid}, 1);
    sync_det = 1'b0; tick(); tick();

    // R8: timeout while settling without sync
    lock_tmo = 16'd3;
    cfg_fam44 = 1'b1; osc_lock = 1'b0;
    tick();
    chk("R7 settle swap", {mclk_valid, osc44_en}, 1);
    repeat (2) tick();
    chk("R8 settle no fault", fault, 0);
    tick();
    chk("R8 settle fault", fault, 1);
    chk("R8 settle clock invalid", mclk_valid, 0);
    osc_lock = 1'b1; tick();
    chk("R8 settle cleared", {fault, mclk_valid}, 1);
    lock_tmo = 16'd50;

    // sweep of measured rates under both family switches
    for (int f = 0; f < 2; f++) begin
      for (int r = 250; r <= 1020; r++) begin
        int v, k48, k44, known, expfam, swp;
        cfg_fam44 = f[0]; sync_det = 1'b0; osc_lock = 1'b1;
        tick(); tick(); tick();
        sync_rate = RATE_W'(r); sync_det = 1'b1; osc_lock = 1'b0;
        tick();
        v      = (r >= 290 && r <= 1000) ? 1 : 0;
        k48    = v & (near(r, 480) | near(r, 960));
        k44    = v & (near(r, 441) | near(r, 882));
        known  = k48 | k44;
        expfam = known ? k44 : f;
        swp    = (expfam != f) ? 1 : 0;
        chk("R3 family", eff_fam44, expfam);
        chk("R2 one osc", osc48_en + osc44_en, 1);
        chk("R5 recovered on acquire", mclk_recov, v);
        chk("R10 sync led", led_sync, v ? ((known && expfam == f) ? 2 : 3) : 1);
        chk("R11 rate led", led_rate, (v && !known) ? 1 : (expfam ? 3 : 2));
        osc_lock = 1'b1;
        tick();
        chk("R5 local after lock", {mclk_recov, mclk_valid}, 1);
        sync_det = 1'b0;
        tick();
        chk("R7 loss", {mclk_valid, eff_fam44}, swp ? f : (2 + f));
        tick();
        chk("R7 settled", {mclk_valid, eff_fam44}, 2 + f);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule